// File: doc/BRIEF.md
# Skid-Buffered Pipeline Stage Stall Controller

This block sits in a multi-lane instruction pipeline between a producing stage upstream and a consuming stage downstream. In each cycle it may receive one bundle of up to `LANES` instruction slots. Each slot carries a valid bit, a kill flag and a payload. The block forwards the surviving slots downstream in the same cycle. It watches three independent stall requests from later stages, plus a flush request and a flush-in-progress indication from the final stage.

When a stall request arrives, the bundle arriving in that cycle is kept whole in a small bundle FIFO, and the block raises `up_stall` to the producer. While the stall lasts, any further bundle that arrives is also queued. Once all stall sources drop, the block drains the FIFO one bundle per cycle, oldest first. Any new bundle that arrives during the drain is appended behind the queued ones, so program order is preserved. `up_stall` stays high until the FIFO is empty. A flush empties the FIFO and discards the live bundle. Killed slots are never forwarded, and the surviving slots are compacted toward lane 0. Saturating counters record how many cycles are spent in each waiting state and how many slots are forwarded or dropped.

The controller is a five-state machine with these encodings on `state_o`: IDLE=0, RUN=1, BLOCK=2, UNBLK=3, SQSH=4. Its transitions are named as follows:
- *stall-in*: IDLE/RUN/UNBLK go to BLOCK.
- *release*: BLOCK goes to UNBLK, or to RUN when nothing is buffered.
- *drained*: UNBLK goes to RUN.
- *flush*: any state goes to SQSH.
- *resume*: SQSH goes to RUN.
- *go-quiet*: RUN goes to IDLE.
- *go-busy*: IDLE goes to RUN.

Top module: `pipe_skid_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (IDLE), `up_stall` is 0, `out_valid` is 0 and every counter reads 0.
- R2: When any of `rn_stall`, `ex_stall` or `cm_stall` is high, `cm_squash` is low and the state is not SQSH, the next state is BLOCK. The bundle present in that cycle is queued if any `in_valid` bit is set. Nothing is forwarded in that cycle, nor in any BLOCK or SQSH cycle.
- R3: In BLOCK, each bundle with at least one valid slot is appended to the FIFO. `up_stall` is 1 in every BLOCK and UNBLK cycle and 0 in every other state.
- R4: In BLOCK with all three stall inputs low, the next state is UNBLK if the FIFO is non-empty or receives a bundle in that cycle; otherwise it is RUN. The FIFO holds `SKID_DEPTH` bundles. The producer must stop within one cycle of seeing `up_stall`.
- R5: In UNBLK with no stall, the head bundle is forwarded and popped, and a valid live bundle is appended. The state goes to RUN after the last buffered bundle leaves. A stall input in UNBLK returns the state to BLOCK without popping. Slots leave in the order they arrived.
- R6: `cm_squash` overrides every stall input. It empties the FIFO, discards the live bundle and makes the next state SQSH. The state stays in SQSH while `cm_squash` or `cm_rob_busy` is high, and then goes to RUN. Bundles presented in SQSH are discarded.
- R7: In a forwarding cycle, slot i (payload `in_data[i*DATA_W +: DATA_W]`, valid `in_valid[i]`, kill `in_kill[i]`) is forwarded when it is valid and not killed. Forwarded slots occupy output lanes 0, 1, 2, … in rising slot order, so the set bits of `out_valid` always form a contiguous run starting at bit 0.
- R8: In IDLE or RUN with no stall, the live bundle is forwarded in the same cycle. The next state is RUN if any `in_valid` bit was set, and IDLE if none was.
- R9: `cnt_idle`, `cnt_block`, `cnt_unblk` and `cnt_squash` each add 1 at each clock edge at which the state is IDLE, BLOCK, UNBLK or SQSH respectively, and each holds at its maximum value.
- R10: `cnt_fwd` adds the number of set `out_valid` bits in each cycle. `cnt_drop` adds the number of valid killed slots in each forwarded bundle. Both saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | LANES | Per-slot valid of the live bundle |
| in_kill | input | LANES | Per-slot kill flag of the live bundle |
| in_data | input | LANES*DATA_W | Per-slot payload, slot i at bits i*DATA_W |
| rn_stall | input | 1 | Stall request from the first later stage |
| ex_stall | input | 1 | Stall request from the execute stage |
| cm_stall | input | 1 | Stall request from the final stage |
| cm_squash | input | 1 | Flush request from the final stage |
| cm_rob_busy | input | 1 | Flush still in progress in the final stage |
| out_valid | output | LANES | Compacted valid lanes to downstream |
| out_data | output | LANES*DATA_W | Compacted payloads to downstream |
| up_stall | output | 1 | Stall to the producing stage |
| state_o | output | 3 | Current state code |
| cnt_idle | output | CNT_W | Cycles spent in IDLE |
| cnt_block | output | CNT_W | Cycles spent in BLOCK |
| cnt_unblk | output | CNT_W | Cycles spent in UNBLK |
| cnt_squash | output | CNT_W | Cycles spent in SQSH |
| cnt_fwd | output | CNT_W | Slots forwarded |
| cnt_drop | output | CNT_W | Killed slots dropped |

## Verification
The main function is tried with four kinds of input:
- A single bundle with a killed middle slot shows whether compaction shifts the later slot down into the gap.
- A three-bundle stall-and-drain sequence, with a new bundle arriving during the drain, shows whether queued bundles leave ahead of fresher ones. The same sequence pins the BLOCK and UNBLK cycle counts.
- A flush that lands while two bundles are queued, followed by a bundle sent during SQSH, shows whether stale work can leak out after recovery.
- A long stretch of random bundles, kill masks and stall bursts, with a producer that reacts one cycle late, checks ordering and counter totals against a scoreboard. This covers back-to-back stall and release cases that the directed sequences miss.

// File: rtl/psk_pkg.sv
package psk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_BLOCK = 3'd2,
        ST_UNBLK = 3'd3,
        ST_SQSH  = 3'd4
    } psk_state_e;

endpackage

// File: rtl/psk_fifo.sv
module psk_fifo #(
    parameter int BW    = 72,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [BW-1:0] din,
    output logic [BW-1:0] head,
    output logic          empty,
    output logic          one_left,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [BW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign empty    = (cnt == '0);
    assign full     = (cnt == CW'(DEPTH));
    assign one_left = (cnt == CW'(1));
    assign pop_ok   = pop && !empty;
    assign push_ok  = push && (!full || pop_ok);
    assign head     = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R4: a producer that obeys up_stall never writes into a full buffer
    p_push_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> (!full || pop));

    // R6: a flush leaves the buffer empty on the following cycle
    p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/psk_pack.sv
module psk_pack #(
    parameter int LANES  = 4,
    parameter int DATA_W = 16
) (
    input  logic                      en,
    input  logic [LANES-1:0]          vld,
    input  logic [LANES-1:0]          kill,
    input  logic [LANES*DATA_W-1:0]   din,
    output logic [LANES-1:0]          ov,
    output logic [LANES*DATA_W-1:0]   dout,
    output logic [$clog2(LANES+1)-1:0] n_out,
    output logic [$clog2(LANES+1)-1:0] n_drop
);
    localparam int CW = $clog2(LANES + 1);

    always_comb begin
        int k;
        int d;
        ov   = '0;
        dout = '0;
        k    = 0;
        d    = 0;
        for (int i = 0; i < LANES; i++) begin
            if (en && vld[i]) begin
                if (kill[i]) begin
                    d = d + 1;
                end else begin
                    ov[k]                  = 1'b1;
                    dout[k*DATA_W +: DATA_W] = din[i*DATA_W +: DATA_W];
                    k = k + 1;
                end
            end
        end
        n_out  = CW'(k);
        n_drop = CW'(d);
    end
endmodule

// File: rtl/psk_satcnt.sv
module psk_satcnt #(
    parameter int CNT_W = 32,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W:0] sum;

    assign sum = {1'b0, cnt} + (CNT_W + 1)'(inc);

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (sum[CNT_W]) cnt <= '1;
        else                 cnt <= sum[CNT_W-1:0];
    end

    // R9 / R10: once at the ceiling the count stays there
    p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1) |=> (cnt == '1));
endmodule

// File: rtl/psk_fsm.sv
module psk_fsm
    import psk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       live_any,
    input  logic       any_stall,
    input  logic       squash,
    input  logic       rob_busy,
    input  logic       buf_empty,
    input  logic       buf_one,
    output psk_state_e st,
    output logic       fwd_en,
    output logic       sel_buf,
    output logic       push,
    output logic       pop,
    output logic       flush,
    output logic       up_stall
);
    psk_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt      = st;
        fwd_en   = 1'b0;
        sel_buf  = 1'b0;
        push     = 1'b0;
        pop      = 1'b0;
        flush    = 1'b0;
        up_stall = (st == ST_BLOCK) || (st == ST_UNBLK);
        if (squash) begin
            flush = 1'b1;
            nxt   = ST_SQSH;
        end else begin
            unique case (st)
                ST_IDLE, ST_RUN: begin
                    if (any_stall) begin
                        push = live_any;
                        nxt  = ST_BLOCK;
                    end else begin
                        fwd_en = 1'b1;
                        nxt    = live_any ? ST_RUN : ST_IDLE;
                    end
                end
                ST_BLOCK: begin
                    push = live_any;
                    if (!any_stall)
                        nxt = (buf_empty && !live_any) ? ST_RUN : ST_UNBLK;
                end
                ST_UNBLK: begin
                    push = live_any;
                    if (any_stall) begin
                        nxt = ST_BLOCK;
                    end else begin
                        fwd_en  = 1'b1;
                        sel_buf = 1'b1;
                        pop     = 1'b1;
                        nxt     = (buf_one && !live_any) ? ST_RUN : ST_UNBLK;
                    end
                end
                ST_SQSH: begin
                    if (!rob_busy) nxt = ST_RUN;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // R5: draining always has a bundle to take
    p_unblk_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UNBLK) |-> !buf_empty);
endmodule

// File: rtl/pipe_skid_ctrl.sv
module pipe_skid_ctrl
    import psk_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int DATA_W     = 16,
    parameter int SKID_DEPTH = 4,
    parameter int CNT_W      = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         in_valid,
    input  logic [LANES-1:0]         in_kill,
    input  logic [LANES*DATA_W-1:0]  in_data,
    input  logic                     rn_stall,
    input  logic                     ex_stall,
    input  logic                     cm_stall,
    input  logic                     cm_squash,
    input  logic                     cm_rob_busy,
    output logic [LANES-1:0]         out_valid,
    output logic [LANES*DATA_W-1:0]  out_data,
    output logic                     up_stall,
    output logic [2:0]               state_o,
    output logic [CNT_W-1:0]         cnt_idle,
    output logic [CNT_W-1:0]         cnt_block,
    output logic [CNT_W-1:0]         cnt_unblk,
    output logic [CNT_W-1:0]         cnt_squash,
    output logic [CNT_W-1:0]         cnt_fwd,
    output logic [CNT_W-1:0]         cnt_drop
);
    localparam int PW = LANES * DATA_W;
    localparam int BW = 2 * LANES + PW;
    localparam int NW = $clog2(LANES + 1);
    localparam int NCYC = 4;

    psk_state_e        st;
    logic              fwd_en, sel_buf, push, pop, flush;
    logic              buf_empty, buf_one, buf_full;
    logic              any_stall, live_any;
    logic [BW-1:0]     live_bdl, head_bdl, src_bdl;
    logic [NW-1:0]     n_out, n_drop;
    logic [NCYC-1:0]   cyc_flag;
    logic [CNT_W-1:0]  cyc_cnt [NCYC];

    assign any_stall = rn_stall | ex_stall | cm_stall;
    assign live_any  = |in_valid;
    assign live_bdl  = {in_valid, in_kill, in_data};
    assign src_bdl   = sel_buf ? head_bdl : live_bdl;
    assign state_o   = st;

    psk_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .live_any  (live_any),
        .any_stall (any_stall),
        .squash    (cm_squash),
        .rob_busy  (cm_rob_busy),
        .buf_empty (buf_empty),
        .buf_one   (buf_one),
        .st        (st),
        .fwd_en    (fwd_en),
        .sel_buf   (sel_buf),
        .push      (push),
        .pop       (pop),
        .flush     (flush),
        .up_stall  (up_stall)
    );

    psk_fifo #(.BW(BW), .DEPTH(SKID_DEPTH)) u_skid (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .flush    (flush),
        .din      (live_bdl),
        .head     (head_bdl),
        .empty    (buf_empty),
        .one_left (buf_one),
        .full     (buf_full)
    );

    psk_pack #(.LANES(LANES), .DATA_W(DATA_W)) u_pack (
        .en     (fwd_en),
        .vld    (src_bdl[BW-1 -: LANES]),
        .kill   (src_bdl[PW +: LANES]),
        .din    (src_bdl[PW-1:0]),
        .ov     (out_valid),
        .dout   (out_data),
        .n_out  (n_out),
        .n_drop (n_drop)
    );

    assign cyc_flag = {st == ST_SQSH, st == ST_UNBLK, st == ST_BLOCK, st == ST_IDLE};

    for (genvar g = 0; g < NCYC; g++) begin : g_cyc
        psk_satcnt #(.CNT_W(CNT_W), .INC_W(1)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cyc_flag[g]),
            .cnt   (cyc_cnt[g])
        );
    end

    assign cnt_idle   = cyc_cnt[0];
    assign cnt_block  = cyc_cnt[1];
    assign cnt_unblk  = cyc_cnt[2];
    assign cnt_squash = cyc_cnt[3];

    psk_satcnt #(.CNT_W(CNT_W), .INC_W(NW)) u_fwd_cnt (
        .clk (clk), .rst_n (rst_n), .inc (n_out), .cnt (cnt_fwd)
    );

    psk_satcnt #(.CNT_W(CNT_W), .INC_W(NW)) u_drop_cnt (
        .clk (clk), .rst_n (rst_n), .inc (n_drop), .cnt (cnt_drop)
    );

    // R2: a stall request outside a flush lands in BLOCK
    p_stall_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stall && !cm_squash && st != ST_SQSH) |=> (state_o == 3'd2));

    // R2: waiting states forward nothing
    p_quiet_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLOCK || st == ST_SQSH) |-> (out_valid == '0));

    // R6: a flush always lands in SQSH
    p_squash_enters_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cm_squash |=> (state_o == 3'd4));

    // R7: forwarded lanes are packed from lane 0
    p_packed_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid & (out_valid + 1'b1)) == '0));

    // R3: the producer is held for the whole drain
    p_hold_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3) |-> up_stall);

    logic unused_full;
    assign unused_full = buf_full;
endmodule

// File: tb/pipe_skid_ctrl_test.sv
module pipe_skid_ctrl_test;
    localparam int CLK_P = 10;
    localparam int L  = 4;
    localparam int DW = 16;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [L-1:0]  in_valid, in_kill;
    logic [L*DW-1:0] in_data;
    logic          rn_stall, ex_stall, cm_stall, cm_squash, cm_rob_busy;
    logic [L-1:0]  out_valid;
    logic [L*DW-1:0] out_data;
    logic          up_stall;
    logic [2:0]    state_o;
    logic [CW-1:0] cnt_idle, cnt_block, cnt_unblk, cnt_squash, cnt_fwd, cnt_drop;

    pipe_skid_ctrl uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kill(in_kill),
        .in_data(in_data), .rn_stall(rn_stall), .ex_stall(ex_stall),
        .cm_stall(cm_stall), .cm_squash(cm_squash), .cm_rob_busy(cm_rob_busy),
        .out_valid(out_valid), .out_data(out_data), .up_stall(up_stall),
        .state_o(state_o), .cnt_idle(cnt_idle), .cnt_block(cnt_block),
        .cnt_unblk(cnt_unblk), .cnt_squash(cnt_squash), .cnt_fwd(cnt_fwd),
        .cnt_drop(cnt_drop)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int popped = 0;
    int flagged = 0;
    bit done = 0;
    bit ignore_in = 0;
    logic [DW-1:0] tag = 16'h0100;
    logic [DW-1:0] exp_q [$];

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // driver: presents one cycle of inputs and records the expected output stream
    task automatic step(input logic [L-1:0] v, input logic [L-1:0] k,
                        input logic rs, input logic es, input logic cs,
                        input logic sq, input logic rb);
        @(negedge clk);
        in_valid = v; in_kill = k;
        rn_stall = rs; ex_stall = es; cm_stall = cs;
        cm_squash = sq; cm_rob_busy = rb;
        for (int i = 0; i < L; i++) begin
            in_data[i*DW +: DW] = tag;
            tag = tag + 1'b1;
        end
        if (sq) begin
            exp_q.delete();
        end else if (!ignore_in) begin
            for (int i = 0; i < L; i++) begin
                if (v[i] && !k[i]) exp_q.push_back(in_data[i*DW +: DW]);
                if (v[i] && k[i])  flagged++;
            end
        end
        #3;
    endtask

    // monitor: pops the scoreboard for each forwarded lane
    always @(negedge clk) begin
        #2;
        if (rst_n && !done && out_valid != '0) begin
            check("R7 lanes contiguous", 64'((out_valid & (out_valid + 1'b1)) == '0), 64'd1);
            for (int i = 0; i < L; i++) begin
                if (out_valid[i]) begin
                    if (exp_q.size() == 0) begin
                        check("R5 unexpected slot", 64'(out_data[i*DW +: DW]), 64'hFFFF_FFFF);
                    end else begin
                        check("R5 order/R7 payload", 64'(out_data[i*DW +: DW]), 64'(exp_q.pop_front()));
                        popped++;
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        logic [CW-1:0] b_blk, b_unb, b_sq;
        logic prev_us;
        rst_n = 0;
        in_valid = '0; in_kill = '0; in_data = '0;
        rn_stall = 0; ex_stall = 0; cm_stall = 0; cm_squash = 0; cm_rob_busy = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #3;
        // R1 reset state
        check("R1 state", 64'(state_o), 64'd0);
        check("R1 up_stall", 64'(up_stall), 64'd0);
        check("R1 out_valid", 64'(out_valid), 64'd0);
        check("R1 counters", 64'(cnt_block | cnt_unblk | cnt_squash | cnt_fwd | cnt_drop), 64'd0);

        // R7/R8: packing with a killed middle slot, same-cycle forward
        step(4'b1111, 4'b0100, 0, 0, 0, 0, 0);
        check("R8 state idle", 64'(state_o), 64'd0);
        check("R7 packed valid", 64'(out_valid), 64'b0111);
        step(4'b0000, 4'b0000, 0, 0, 0, 0, 0);
        check("R8 state run", 64'(state_o), 64'd1);
        check("R8 no input no output", 64'(out_valid), 64'd0);
        step(4'b0000, 4'b0000, 0, 0, 0, 0, 0);
        check("R8 back to idle", 64'(state_o), 64'd0);

        // R2-R5: stall, buffer, drain with a late arrival
        b_blk = cnt_block; b_unb = cnt_unblk;
        step(4'b1111, 4'b0000, 1, 0, 0, 0, 0);
        check("R2 no forward on stall", 64'(out_valid), 64'd0);
        check("R3 no up_stall yet", 64'(up_stall), 64'd0);
        step(4'b0011, 4'b0000, 0, 1, 0, 0, 0);
        check("R2 state block", 64'(state_o), 64'd2);
        check("R3 up_stall in block", 64'(up_stall), 64'd1);
        check("R2 quiet in block", 64'(out_valid), 64'd0);
        step(4'b0001, 4'b0000, 0, 0, 0, 0, 0);
        check("R2 still quiet", 64'(out_valid), 64'd0);
        step(4'b1000, 4'b0000, 0, 0, 0, 0, 0);
        check("R4 state unblk", 64'(state_o), 64'd3);
        check("R3 up_stall in unblk", 64'(up_stall), 64'd1);
        check("R5 head bundle", 64'(out_valid), 64'b1111);
        step(4'b0000, 4'b0000, 0, 0, 0, 0, 0);
        check("R5 second bundle", 64'(out_valid), 64'b0011);
        step(4'b0000, 4'b0000, 0, 0, 0, 0, 0);
        check("R5 third bundle", 64'(out_valid), 64'b0001);
        step(4'b0000, 4'b0000, 0, 0, 0, 0, 0);
        check("R5 late bundle packed", 64'(out_valid), 64'b0001);
        check("R3 up_stall until drained", 64'(up_stall), 64'd1);
        step(4'b0000, 4'b0000, 0, 0, 0, 0, 0);
        check("R5 drained to run", 64'(state_o), 64'd1);
        check("R3 up_stall released", 64'(up_stall), 64'd0);
        check("R9 block cycles", 64'(cnt_block - b_blk), 64'd2);
        check("R9 unblk cycles", 64'(cnt_unblk - b_unb), 64'd4);

        // R4: release with nothing buffered goes to RUN
        step(4'b0000, 4'b0000, 0, 0, 1, 0, 0);
        step(4'b0000, 4'b0000, 0, 0, 0, 0, 0);
        check("R4 block empty", 64'(state_o), 64'd2);
        step(4'b0000, 4'b0000, 0, 0, 0, 0, 0);
        check("R4 empty release to run", 64'(state_o), 64'd1);

        // R6: flush while two bundles are queued, stall held too
        b_sq = cnt_squash;
        step(4'b1111, 4'b0000, 1, 0, 0, 0, 0);
        step(4'b0011, 4'b0000, 1, 0, 0, 0, 0);
        step(4'b0101, 4'b0000, 1, 0, 0, 1, 0);
        check("R6 no forward on flush", 64'(out_valid), 64'd0);
        step(4'b0000, 4'b0000, 1, 0, 0, 0, 1);
        check("R6 priority over stall", 64'(state_o), 64'd4);
        ignore_in = 1;
        step(4'b1111, 4'b0000, 0, 0, 0, 0, 1);
        check("R6 input ignored", 64'(out_valid), 64'd0);
        ignore_in = 0;
        step(4'b0000, 4'b0000, 0, 0, 0, 0, 0);
        check("R6 still squashing", 64'(state_o), 64'd4);
        check("R3 no up_stall in sqsh", 64'(up_stall), 64'd0);
        step(4'b0000, 4'b0000, 0, 0, 0, 0, 0);
        check("R6 resume to run", 64'(state_o), 64'd1);
        check("R6 nothing stale", 64'(out_valid), 64'd0);
        check("R9 squash cycles", 64'(cnt_squash - b_sq), 64'd3);
        step(4'b0001, 4'b0000, 0, 0, 0, 0, 0);
        check("R6 fresh bundle after flush", 64'(out_valid), 64'b0001);

        // random traffic, producer reacts one cycle late to up_stall
        prev_us = 0;
        for (int c = 0; c < 600; c++) begin
            logic [L-1:0] v, k;
            logic rs, es, cs;
            v  = (!prev_us && ($urandom % 4 != 0)) ? L'($urandom) : '0;
            k  = L'($urandom);
            rs = ($urandom % 8 == 0);
            es = ($urandom % 10 == 0);
            cs = ($urandom % 12 == 0);
            step(v, k, rs, es, cs, 0, 0);
            prev_us = up_stall;
        end
        for (int c = 0; c < 12; c++) step('0, '0, 0, 0, 0, 0, 0);
        check("R5 scoreboard drained", 64'(exp_q.size()), 64'd0);
        check("R10 forwarded count", 64'(cnt_fwd), 64'(popped));
        check("R10 dropped count", 64'(cnt_drop), 64'(flagged));
        finish_run();
    end
endmodule